// File: doc/BRIEF.md
# Address-Collision Busy Arbiter for a Dual-Port Memory

This block sits beside a two-port memory array. Each cycle it compares what the two ports select. A collision exists when both ports are enabled and present the same address. During a collision one port keeps access and the other port sees its active-low busy output pulled low. The block also produces a per-port write-enable qualifier that the array uses as its write strobe. A port that has been held off cannot write until one full cycle after its busy output has been released.

The race between the two ports is modelled on clock edges. The port whose enable and address were already settled in the previous cycle is treated as the earlier one and wins. If both ports arrive in the same cycle, the left port wins. Once a winner is chosen it is kept for as long as the collision lasts. Whether either access is a read or a write plays no part in the arbitration.

Top module: `collision_busy_arb`

## Requirements
- R1: Both busy outputs stay high whenever there is no match. A match means both active-low enables are 0 and the two addresses are equal. This also holds straight after reset.
- R2: The write selects (active low, 0 = write) do not affect which port receives busy.
- R3: At the first cycle of a match, if exactly one port changed its enable or address since the previous cycle, the unchanged port wins. The changed port's busy goes low in that same cycle.
- R4: The two busy outputs are never low together.
- R5: If both ports changed in the cycle where the match begins, the right port receives busy.
- R6: While a port's busy is low, that port's write-enable qualifier is 0.
- R7: While a match persists from one cycle to the next, the port holding busy keeps it.
- R8: Busy is released (high) in the first cycle in which either enable is 1 or the addresses differ.
- R9: In the cycle right after a port's busy was low, that port's write-enable qualifier is still 0.
- R10: The write-enable qualifier of a port is 1 exactly when its enable is 0, its write select is 0, its busy is high, and its busy was also high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_l_n | input | 1 | Left enable, active low |
| wr_l_n | input | 1 | Left write select, 0 = write |
| addr_l | input | 11 | Left address |
| ce_r_n | input | 1 | Right enable, active low |
| wr_r_n | input | 1 | Right write select, 0 = write |
| addr_r | input | 11 | Right address |
| busy_l_n | output | 1 | Left busy, active low |
| busy_r_n | output | 1 | Right busy, active low |
| wen_l | output | 1 | Left write strobe to the array |
| wen_r | output | 1 | Right write strobe to the array |

## Verification
The properties assume that the port inputs change only once per cycle, away from the sampling edge. They also assume that the inputs hold an idle value (both enables high) during reset, so that the first post-reset cycle has a defined history. The bench drives every input on the falling edge and keeps both enables high while reset is asserted. Its sweep draws addresses from a three-value set, so that collisions begin, persist, end and tie often. A reference model of the priority rules supplies the expected value for each cycle.

// File: rtl/dpbusy_pkg.sv
package dpbusy_pkg;

    parameter int unsigned ADDR_W = 11;
    localparam int unsigned NPORTS = 2;

    typedef enum logic {
        WIN_LEFT  = 1'b0,
        WIN_RIGHT = 1'b1
    } winner_e;

    typedef struct packed {
        logic              sel;
        logic [ADDR_W-1:0] addr;
    } port_req_t;

    function automatic logic same_target(input port_req_t a, input port_req_t b);
        return a.sel && b.sel && (a.addr == b.addr);
    endfunction

    function automatic port_req_t make_req(input logic ce_n, input logic [ADDR_W-1:0] addr);
        port_req_t r;
        r.sel  = !ce_n;
        r.addr = addr;
        return r;
    endfunction

endpackage

// File: rtl/dpbusy_match.sv
module dpbusy_match
    import dpbusy_pkg::*;
(
    input  port_req_t req_l,
    input  port_req_t req_r,
    output logic      hit
);
    always_comb hit = same_target(req_l, req_r);
endmodule

// File: rtl/dpbusy_arbiter.sv
module dpbusy_arbiter
    import dpbusy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_req_t req_l,
    input  port_req_t req_r,
    input  logic      hit,
    output logic      busy_l_n,
    output logic      busy_r_n
);
    port_req_t prev_l, prev_r;
    logic      hit_q;
    winner_e   winner_q, fresh, winner;
    logic      moved_l, moved_r, onset;

    always_comb begin
        moved_l = (prev_l != req_l);
        moved_r = (prev_r != req_r);
        onset   = hit && !hit_q;
        // the side that arrived while the other was already settled loses
        fresh   = (moved_l && !moved_r) ? WIN_RIGHT : WIN_LEFT;
        winner  = onset ? fresh : winner_q;
        busy_l_n = !(hit && (winner == WIN_RIGHT));
        busy_r_n = !(hit && (winner == WIN_LEFT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_l   <= '{sel: 1'b0, addr: '0};
            prev_r   <= '{sel: 1'b0, addr: '0};
            hit_q    <= 1'b0;
            winner_q <= WIN_LEFT;
        end else begin
            prev_l   <= req_l;
            prev_r   <= req_r;
            hit_q    <= hit;
            winner_q <= winner;
        end
    end
endmodule

// File: rtl/dpbusy_wrgate.sv
module dpbusy_wrgate (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic wr_n,
    input  logic busy_n,
    output logic wen
);
    logic held_q;

    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b0;
        else     held_q <= !busy_n;
    end

    always_comb wen = sel && !wr_n && busy_n && !held_q;
endmodule

// File: rtl/collision_busy_arb.sv
module collision_busy_arb
    import dpbusy_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_l_n,
    input  logic              wr_l_n,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic              ce_r_n,
    input  logic              wr_r_n,
    input  logic [ADDR_W-1:0] addr_r,
    output logic              busy_l_n,
    output logic              busy_r_n,
    output logic              wen_l,
    output logic              wen_r
);
    port_req_t         req [NPORTS];
    logic [NPORTS-1:0] wsel_n, bsy_n, wen_v;
    logic              hit;

    always_comb begin
        req[0]    = make_req(ce_l_n, addr_l);
        req[1]    = make_req(ce_r_n, addr_r);
        wsel_n[0] = wr_l_n;
        wsel_n[1] = wr_r_n;
    end

    dpbusy_match u_match (
        .req_l (req[0]),
        .req_r (req[1]),
        .hit   (hit)
    );

    dpbusy_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .req_l    (req[0]),
        .req_r    (req[1]),
        .hit      (hit),
        .busy_l_n (bsy_n[0]),
        .busy_r_n (bsy_n[1])
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        dpbusy_wrgate u_gate (
            .clk    (clk),
            .rst    (rst),
            .sel    (req[p].sel),
            .wr_n   (wsel_n[p]),
            .busy_n (bsy_n[p]),
            .wen    (wen_v[p])
        );
    end

    assign busy_l_n = bsy_n[0];
    assign busy_r_n = bsy_n[1];
    assign wen_l    = wen_v[0];
    assign wen_r    = wen_v[1];
endmodule

// File: rtl/dpbusy_checker.sv
module dpbusy_checker
    import dpbusy_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_l_n,
    input logic              wr_l_n,
    input logic [ADDR_W-1:0] addr_l,
    input logic              ce_r_n,
    input logic              wr_r_n,
    input logic [ADDR_W-1:0] addr_r,
    input logic              busy_l_n,
    input logic              busy_r_n,
    input logic              wen_l,
    input logic              wen_r
);
    logic seen;
    logic coll;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    always_comb coll = !ce_l_n && !ce_r_n && (addr_l == addr_r);

    a_r1_no_match_idle: assert property (@(posedge clk) disable iff (rst)
        !coll |-> (busy_l_n && busy_r_n));

    a_r4_never_both_busy: assert property (@(posedge clk) disable iff (rst)
        busy_l_n || busy_r_n);

    a_r6_gate_left: assert property (@(posedge clk) disable iff (rst)
        !busy_l_n |-> !wen_l);

    a_r6_gate_right: assert property (@(posedge clk) disable iff (rst)
        !busy_r_n |-> !wen_r);

    a_r7_hold_left: assert property (@(posedge clk) disable iff (rst)
        (seen && coll && $past(coll) && !$past(busy_l_n)) |-> !busy_l_n);

    a_r7_hold_right: assert property (@(posedge clk) disable iff (rst)
        (seen && coll && $past(coll) && !$past(busy_r_n)) |-> !busy_r_n);

    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (ce_l_n || ce_r_n || (addr_l != addr_r)) |-> (busy_l_n && busy_r_n));

    a_r9_left_wait: assert property (@(posedge clk) disable iff (rst)
        (seen && !$past(busy_l_n)) |-> !wen_l);

    a_r9_right_wait: assert property (@(posedge clk) disable iff (rst)
        (seen && !$past(busy_r_n)) |-> !wen_r);

    a_r10_left_req: assert property (@(posedge clk) disable iff (rst)
        wen_l |-> (!ce_l_n && !wr_l_n));

    a_r10_right_req: assert property (@(posedge clk) disable iff (rst)
        wen_r |-> (!ce_r_n && !wr_r_n));
endmodule

bind collision_busy_arb dpbusy_checker u_chk (.*);

// File: tb/collision_busy_arb_bench.sv
module collision_busy_arb_bench;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst;
    logic          ce_l_n, wr_l_n, ce_r_n, wr_r_n;
    logic [AW-1:0] addr_l, addr_r;
    logic          busy_l_n, busy_r_n, wen_l, wen_r;

    int checks = 0;
    int errors = 0;

    // reference state
    logic          m_ce_l = 1'b1, m_ce_r = 1'b1;
    logic [AW-1:0] m_a_l = '0, m_a_r = '0;
    logic          m_hit = 1'b0, m_win_r = 1'b0;
    logic          m_bl_prev = 1'b0, m_br_prev = 1'b0;

    always #2.5 clk = ~clk;

    collision_busy_arb u_collision_busy_arb (
        .clk(clk), .rst(rst),
        .ce_l_n(ce_l_n), .wr_l_n(wr_l_n), .addr_l(addr_l),
        .ce_r_n(ce_r_n), .wr_r_n(wr_r_n), .addr_r(addr_r),
        .busy_l_n(busy_l_n), .busy_r_n(busy_r_n), .wen_l(wen_l), .wen_r(wen_r)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic cl, input logic wl, input logic [AW-1:0] al,
                        input logic cr, input logic wr, input logic [AW-1:0] ar);
        logic  m, onset, mv_l, mv_r, win_r, ebl, ebr, ewl, ewr;
        string tb, twl, twr;
        @(negedge clk);
        ce_l_n = cl; wr_l_n = wl; addr_l = al;
        ce_r_n = cr; wr_r_n = wr; addr_r = ar;
        #1;
        m     = !cl && !cr && (al == ar);
        onset = m && !m_hit;
        mv_l  = (m_ce_l != cl) || (m_a_l != al);
        mv_r  = (m_ce_r != cr) || (m_a_r != ar);
        win_r = onset ? (mv_l && !mv_r ? 1'b0 : 1'b1) : m_win_r;
        // win_r = 1 means the right port is the one that gets busy
        ebl = !(m && !win_r);
        ebr = !(m && win_r);
        ewl = !cl && !wl && ebl && !m_bl_prev;
        ewr = !cr && !wr && ebr && !m_br_prev;
        if (!m)          tb = m_hit ? "R8 release" : "R1 no match";
        else if (onset)  tb = (mv_l && mv_r) ? "R5 tie" : "R3 earlier wins";
        else             tb = "R7 held";
        twl = !ebl ? "R6 gated" : (m_bl_prev ? "R9 wait" : "R10 qualifier");
        twr = !ebr ? "R6 gated" : (m_br_prev ? "R9 wait" : "R10 qualifier");
        chk({tb, " busy_l_n"}, busy_l_n, ebl);
        chk({tb, " busy_r_n"}, busy_r_n, ebr);
        chk({twl, " wen_l"}, wen_l, ewl);
        chk({twr, " wen_r"}, wen_r, ewr);
        chk("R4 exclusive busy", busy_l_n | busy_r_n, 1'b1);
        m_ce_l = cl; m_a_l = al; m_ce_r = cr; m_a_r = ar;
        m_hit = m; m_win_r = win_r; m_bl_prev = !ebl; m_br_prev = !ebr;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [AW-1:0] pick [3];
        pick[0] = 11'h000; pick[1] = 11'h001; pick[2] = 11'h7FF;
        rst = 1'b1;
        ce_l_n = 1'b1; wr_l_n = 1'b1; addr_l = '0;
        ce_r_n = 1'b1; wr_r_n = 1'b1; addr_r = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset busy_l_n", busy_l_n, 1'b1);
        chk("R1 reset busy_r_n", busy_r_n, 1'b1);
        @(negedge clk);
        rst = 1'b0;

        // R2/R3: left settled reading, right arrives writing -> right busy
        step(0, 1, 11'd5, 1, 1, 11'd0);
        step(0, 1, 11'd5, 0, 0, 11'd5);
        chk("R2 read/write ignored busy_r_n", busy_r_n, 1'b0);
        step(1, 1, 11'd5, 1, 1, 11'd5);
        // R2: same race with write on left, read on right -> same outcome
        step(0, 0, 11'd5, 1, 1, 11'd0);
        step(0, 0, 11'd5, 0, 1, 11'd5);
        chk("R2 read/write ignored busy_r_n", busy_r_n, 1'b0);
        step(1, 1, 11'd5, 1, 1, 11'd5);
        // R3: right settled first, left arrives -> left busy, held (R7)
        step(1, 1, 11'd3, 0, 0, 11'd3);
        step(0, 0, 11'd3, 0, 0, 11'd3);
        chk("R3 right earlier busy_l_n", busy_l_n, 1'b0);
        step(0, 0, 11'd3, 0, 0, 11'd3);
        step(0, 0, 11'd3, 0, 0, 11'd3);
        chk("R7 held busy_l_n", busy_l_n, 1'b0);
        // R8/R9: right leaves, left freed but waits one cycle, then R10
        step(0, 0, 11'd3, 0, 0, 11'd4);
        chk("R9 wait wen_l", wen_l, 1'b0);
        step(0, 0, 11'd3, 0, 0, 11'd4);
        chk("R10 qualifier wen_l", wen_l, 1'b1);
        // R5: both arrive together -> right busy
        step(1, 1, 11'd0, 1, 1, 11'd0);
        step(0, 0, 11'h7FF, 0, 0, 11'h7FF);
        chk("R5 tie busy_r_n", busy_r_n, 1'b0);
        chk("R6 gated wen_r", wen_r, 1'b0);
        step(1, 0, 11'h7FF, 0, 0, 11'h7FF);
        chk("R8 release busy_r_n", busy_r_n, 1'b1);

        // sweep
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[1:0] == 2'b11, lfsr[2], pick[lfsr[4:3] % 3],
                 lfsr[6:5] == 2'b11, lfsr[7], pick[lfsr[9:8] % 3]);
            if (lfsr[11]) step(m_ce_l, lfsr[12], m_a_l, m_ce_r, lfsr[13], m_a_r);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule